// File: doc/BRIEF.md
# DRAM Write Command and Data Phase Aligner

This block sits between a simple memory controller and a multi-phase DRAM PHY. Each controller clock cycle carries `NPHASES` DRAM clock slots, and the PHY takes a separate command, data, data-enable and mask field for every slot. The aligner accepts one read or write request through a valid/ready handshake. It puts the command in the command slot. For a write, it puts the data in the data slot. The command slot and the data slot are both parameters: an SDR PHY uses the same index for both, and a DDR PHY puts the data slot one DRAM clock after the command slot.

The byte masks are active high: a mask bit of 1 suppresses that byte. Each mask bit is the inverse of the matching bus byte select. The masks are driven on every slot and for reads as well as writes, and they keep the value of the most recent operation until the next one. A partial write therefore never disturbs the neighbouring bytes. A read never sees a forced-high mask, which would tri-state the data lines. If the data slot index is lower than the command slot index, the data goes out in the following controller cycle. The request stays blocked until both slots have been issued.

Top module: `ddr_wr_phase_align`

## Requirements
- R1: After synchronous reset, `req_ready` is 1 and every command-valid, command-write, data-enable, data and mask output is 0.
- R2: The cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge), `phy_cmd_valid` has only bit `CMD_PHASE` set (bit 0 by default), and `phy_cmd_addr` carries the request address.
- R3: For an accepted write, `phy_cmd_we` bit `CMD_PHASE` is 1 in the command cycle. The write data appears in slice `DATA_PHASE` of `phy_wrdata` (bits 63:32 by default), with only `phy_wrdata_en` bit `DATA_PHASE` set. This happens in the same cycle when `DATA_PHASE >= CMD_PHASE`. All other data slices are 0.
- R4: Mask bit `p*BYTES+b` equals the inverse of `req_sel[b]` of the accepted operation, for every slot `p` and every lane `b`. This includes all-zero selects (all-ones mask) and partial selects.
- R5: An accepted read gives a command with `phy_cmd_we` all 0, raises no data enable and drives all-zero data. Its masks still follow R4, and the request data input has no effect on the outputs.
- R6: Between operations the masks hold the value set by the last accepted operation.
- R7: `req_ready` is 0 in every cycle in which an accepted operation is being issued. A request held valid during those cycles is not accepted again until `req_ready` returns to 1.
- R8: In a cycle that does not follow an acceptance, and has no pending data slot, all command-valid and data-enable outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Aligner can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Write data |
| req_sel | input | DATA_W/8 | Bus byte selects, 1 = byte used |
| phy_cmd_valid | output | NPHASES | Command strobe per slot |
| phy_cmd_we | output | NPHASES | Write flag per slot |
| phy_cmd_addr | output | ADDR_W | Command address |
| phy_wrdata_en | output | NPHASES | Write data enable per slot |
| phy_wrdata | output | NPHASES*DATA_W | Write data, slot p at bits p*DATA_W |
| phy_wrmask | output | NPHASES*DATA_W/8 | Byte masks, 1 = byte suppressed |

## Verification
The bench checks the slot placement: if the command went into the data slot, or the data went into the command slot, the wrong bit of `phy_cmd_valid` or the wrong half of `phy_wrdata` would light up. Mask polarity is tested with full, single-lane, split and empty selects, so a tied-low or uninverted mask shows up at once. It also checks that a mask is driven for a read, and that it holds through the idle cycle. A request is kept valid across the blocked cycle, so a design that ignores its own ready would issue the same command twice. A read with non-zero request data catches a design that leaks data or a data enable onto a read.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

    typedef enum logic [1:0] {
        WPA_IDLE  = 2'd0,
        WPA_ISSUE = 2'd1,
        WPA_DATA  = 2'd2
    } wpa_state_e;

    // Data lands in the next controller cycle when its slot precedes the command slot.
    function automatic bit data_wraps(input int cmd_phase, input int data_phase);
        return data_phase < cmd_phase;
    endfunction

    function automatic int lanes_of(input int data_w);
        return data_w / 8;
    endfunction

endpackage

// File: rtl/wpa_sched.sv
module wpa_sched
    import wpa_pkg::*;
#(
    parameter bit WRAP = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_we,
    output logic req_ready,
    output logic accept,
    output logic load_cmd,
    output logic load_data,
    output logic data_from_hold
);
    wpa_state_e state_q, state_d;

    always_comb begin
        state_d        = state_q;
        req_ready      = 1'b0;
        accept         = 1'b0;
        load_cmd       = 1'b0;
        load_data      = 1'b0;
        data_from_hold = 1'b0;
        unique case (state_q)
            WPA_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    accept   = 1'b1;
                    load_cmd = 1'b1;
                    if (req_we && WRAP) begin
                        state_d = WPA_DATA;
                    end else begin
                        load_data = req_we;
                        state_d   = WPA_ISSUE;
                    end
                end
            end
            WPA_DATA: begin
                load_data      = 1'b1;
                data_from_hold = 1'b1;
                state_d        = WPA_ISSUE;
            end
            WPA_ISSUE: begin
                state_d = WPA_IDLE;
            end
            default: state_d = WPA_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WPA_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/wpa_mask_gen.sv
module wpa_mask_gen #(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] sel,
    output logic [LANES-1:0] mask
);
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign mask[b] = ~sel[b];
    end
endmodule

// File: rtl/wpa_slot_reg.sv
module wpa_slot_reg #(
    parameter int DATA_W  = 32,
    parameter bit IS_CMD  = 1'b0,
    parameter bit IS_DATA = 1'b0,
    localparam int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_cmd,
    input  logic              load_data,
    input  logic              op_we,
    input  logic [DATA_W-1:0] op_data,
    input  logic [LANES-1:0]  op_mask,
    output logic              cmd_valid,
    output logic              cmd_we,
    output logic              data_en,
    output logic [DATA_W-1:0] data,
    output logic [LANES-1:0]  mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            cmd_we    <= 1'b0;
            data_en   <= 1'b0;
            data      <= '0;
            mask      <= '0;
        end else begin
            cmd_valid <= IS_CMD && load_cmd;
            cmd_we    <= IS_CMD && load_cmd && op_we;
            data_en   <= IS_DATA && load_data;
            data      <= (IS_DATA && load_data) ? op_data : '0;
            if (load_cmd) mask <= op_mask;
        end
    end
endmodule

// File: rtl/ddr_wr_phase_align.sv
module ddr_wr_phase_align
    import wpa_pkg::*;
#(
    parameter int NPHASES    = 2,
    parameter int CMD_PHASE  = 0,
    parameter int DATA_PHASE = 1,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    output logic                              req_ready,
    input  logic                              req_we,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [DATA_W-1:0]                 req_data,
    input  logic [DATA_W/8-1:0]               req_sel,
    output logic [NPHASES-1:0]                phy_cmd_valid,
    output logic [NPHASES-1:0]                phy_cmd_we,
    output logic [ADDR_W-1:0]                 phy_cmd_addr,
    output logic [NPHASES-1:0]                phy_wrdata_en,
    output logic [NPHASES*DATA_W-1:0]         phy_wrdata,
    output logic [NPHASES*(DATA_W/8)-1:0]     phy_wrmask
);
    localparam int LANES = lanes_of(DATA_W);
    localparam bit WRAP  = data_wraps(CMD_PHASE, DATA_PHASE);

    logic              accept, load_cmd, load_data, data_from_hold;
    logic [DATA_W-1:0] hold_data, data_src;
    logic [LANES-1:0]  new_mask;

    wpa_sched #(.WRAP(WRAP)) i_sched (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_we         (req_we),
        .req_ready      (req_ready),
        .accept         (accept),
        .load_cmd       (load_cmd),
        .load_data      (load_data),
        .data_from_hold (data_from_hold)
    );

    wpa_mask_gen #(.LANES(LANES)) i_mask (
        .sel  (req_sel),
        .mask (new_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data    <= '0;
            phy_cmd_addr <= '0;
        end else if (accept) begin
            hold_data    <= req_data;
            phy_cmd_addr <= req_addr;
        end
    end

    assign data_src = data_from_hold ? hold_data : req_data;

    for (genvar p = 0; p < NPHASES; p++) begin : g_slot
        wpa_slot_reg #(
            .DATA_W  (DATA_W),
            .IS_CMD  (p == CMD_PHASE),
            .IS_DATA (p == DATA_PHASE)
        ) i_slot (
            .clk       (clk),
            .rst       (rst),
            .load_cmd  (load_cmd),
            .load_data (load_data),
            .op_we     (req_we),
            .op_data   (data_src),
            .op_mask   (new_mask),
            .cmd_valid (phy_cmd_valid[p]),
            .cmd_we    (phy_cmd_we[p]),
            .data_en   (phy_wrdata_en[p]),
            .data      (phy_wrdata[p*DATA_W +: DATA_W]),
            .mask      (phy_wrmask[p*LANES +: LANES])
        );
    end
endmodule

// File: rtl/wpa_checker.sv
module wpa_checker #(
    parameter int NPHASES    = 2,
    parameter int CMD_PHASE  = 0,
    parameter int DATA_PHASE = 1,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 16,
    localparam int LANES     = DATA_W / 8
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic                       req_we,
    input logic [ADDR_W-1:0]          req_addr,
    input logic [LANES-1:0]           req_sel,
    input logic [NPHASES-1:0]         phy_cmd_valid,
    input logic [NPHASES-1:0]         phy_cmd_we,
    input logic [ADDR_W-1:0]          phy_cmd_addr,
    input logic [NPHASES-1:0]         phy_wrdata_en,
    input logic [NPHASES*LANES-1:0]   phy_wrmask
);
    localparam logic [NPHASES-1:0] CMD_BIT  = NPHASES'(1) << CMD_PHASE;
    localparam logic [NPHASES-1:0] DATA_BIT = NPHASES'(1) << DATA_PHASE;

    assert_cmd_slot_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (phy_cmd_valid == CMD_BIT) && (phy_cmd_addr == $past(req_addr)))
        else $error("command slot or address wrong");

    assert_no_idle_cmd_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid && req_ready) |-> (phy_cmd_valid == '0))
        else $error("command without acceptance");

    assert_data_slot_R3: assert property (@(posedge clk) disable iff (rst)
        (phy_wrdata_en != '0) |-> (phy_wrdata_en == DATA_BIT))
        else $error("data enable outside data slot");

    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready)
        else $error("ready high while issuing");

    assert_mask_new_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (phy_wrmask[LANES-1:0] == ~$past(req_sel)))
        else $error("mask not inverted select");

    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(req_valid && req_ready) |-> $stable(phy_wrmask))
        else $error("mask changed without operation");

    assert_read_no_data_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_we) |=> (phy_cmd_we == '0))
        else $error("read flagged as write");

    always @(posedge clk) begin
        if (!rst) begin
            for (int p = 1; p < NPHASES; p++) begin
                assert_mask_lanes_R4: assert (phy_wrmask[p*LANES +: LANES] == phy_wrmask[LANES-1:0])
                    else $error("mask differs between slots");
            end
        end
    end
endmodule

bind ddr_wr_phase_align wpa_checker #(
    .NPHASES(NPHASES), .CMD_PHASE(CMD_PHASE), .DATA_PHASE(DATA_PHASE),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) i_wpa_checker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_sel(req_sel),
    .phy_cmd_valid(phy_cmd_valid), .phy_cmd_we(phy_cmd_we),
    .phy_cmd_addr(phy_cmd_addr), .phy_wrdata_en(phy_wrdata_en),
    .phy_wrmask(phy_wrmask)
);

// File: tb/test_ddr_wr_phase_align.sv
module test_ddr_wr_phase_align;
    localparam int NV = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [3:0]  req_sel = '0;
    logic [1:0]  phy_cmd_valid, phy_cmd_we, phy_wrdata_en;
    logic [15:0] phy_cmd_addr;
    logic [63:0] phy_wrdata;
    logic [7:0]  phy_wrmask;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // {we, addr, data, sel}
    localparam logic [52:0] VEC [NV] = '{
        {1'b1, 16'h0010, 32'hA1B2C3D4, 4'hF},
        {1'b1, 16'h0124, 32'h11223344, 4'h1},
        {1'b1, 16'h0FF8, 32'hDEADBEEF, 4'h0},
        {1'b0, 16'h2000, 32'h00000000, 4'hF},
        {1'b1, 16'h7FFC, 32'hCAFEF00D, 4'h6},
        {1'b0, 16'h0304, 32'h55AA55AA, 4'h9}
    };

    always #2 clk = ~clk;

    ddr_wr_phase_align i_ddr_wr_phase_align (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_data(req_data), .req_sel(req_sel),
        .phy_cmd_valid(phy_cmd_valid), .phy_cmd_we(phy_cmd_we), .phy_cmd_addr(phy_cmd_addr),
        .phy_wrdata_en(phy_wrdata_en), .phy_wrdata(phy_wrdata), .phy_wrmask(phy_wrmask)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_issue(input bit we, input logic [15:0] addr, input logic [31:0] data, input logic [3:0] sel);
        check(phy_cmd_valid == 2'b01, "R2 cmd slot", 64'(phy_cmd_valid), 64'h1);
        check(phy_cmd_addr == addr, "R2 cmd addr", 64'(phy_cmd_addr), 64'(addr));
        check(phy_cmd_we == {1'b0, we}, "R3 R5 cmd we", 64'(phy_cmd_we), 64'({1'b0, we}));
        check(phy_wrdata_en == (we ? 2'b10 : 2'b00), "R3 R5 data enable", 64'(phy_wrdata_en), 64'(we ? 2'b10 : 2'b00));
        check(phy_wrdata == {(we ? data : 32'h0), 32'h0}, "R3 R5 data slot", phy_wrdata, {(we ? data : 32'h0), 32'h0});
        check(phy_wrmask == {~sel, ~sel}, "R4 mask", 64'(phy_wrmask), 64'({~sel, ~sel}));
        check(req_ready == 1'b0, "R7 ready low issuing", 64'(req_ready), 64'h0);
    endtask

    task automatic check_idle(input logic [3:0] sel);
        check(phy_cmd_valid == 2'b00 && phy_wrdata_en == 2'b00, "R8 idle strobes",
              64'({phy_cmd_valid, phy_wrdata_en}), 64'h0);
        check(phy_wrmask == {~sel, ~sel}, "R6 mask hold", 64'(phy_wrmask), 64'({~sel, ~sel}));
        check(req_ready == 1'b1, "R7 ready back", 64'(req_ready), 64'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        check(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'h1);
        check(phy_cmd_valid == 0 && phy_cmd_we == 0 && phy_wrdata_en == 0, "R1 strobes",
              64'({phy_cmd_valid, phy_cmd_we, phy_wrdata_en}), 64'h0);
        check(phy_wrdata == 0 && phy_wrmask == 0, "R1 data mask", 64'(phy_wrmask), 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic [52:0] v;
            v = VEC[i];
            req_valid = 1'b1;
            req_we    = v[52];
            req_addr  = v[51:36];
            req_data  = v[35:4];
            req_sel   = v[3:0];
            @(negedge clk);
            req_valid = 1'b0;
            check_issue(v[52], v[51:36], v[35:4], v[3:0]);
            @(negedge clk);
            check_idle(v[3:0]);
        end

        // R7: valid held through the blocked cycle is accepted only once
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h0ABC; req_data = 32'h0BADF00D; req_sel = 4'hC;
        @(negedge clk);
        check_issue(1'b1, 16'h0ABC, 32'h0BADF00D, 4'hC);
        req_addr = 16'h0DEF; req_sel = 4'h3;
        @(negedge clk);
        check(phy_cmd_valid == 2'b00, "R7 no accept while blocked", 64'(phy_cmd_valid), 64'h0);
        check(phy_wrmask == {4'h3, 4'h3}, "R7 R6 mask unchanged while blocked", 64'(phy_wrmask), 64'h33);
        @(negedge clk);
        req_valid = 1'b0;
        check_issue(1'b1, 16'h0DEF, 32'h0BADF00D, 4'h3);
        @(negedge clk);
        check_idle(4'h3);
        // R6: several idle cycles keep the mask
        repeat (4) @(negedge clk);
        check_idle(4'h3);
        done = 1;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
    end

    initial begin
        wait (done || $time > 8000);
        #1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule